// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is a synthesizable model of a word-organised serial EEPROM that sits on a three-wire Microwire bus. It has a chip select, a serial clock and a serial data input. Its data output is tri-state in behaviour: a separate enable pin marks when the pin is driven. All three bus inputs are brought into the system clock domain through a synchronizer chain, and edges are detected there. Each instruction is a start bit, a two-bit opcode and an address. With these the block reads or programs an internal array of 2^ADDR_W words, each DATA_W bits wide.

Programming is self-timed. Once a complete erase or write command has been received, the falling edge of chip select starts a counter of PROG_CYCLES system clocks. While that counter runs, the array is busy. If the host raises chip select again during this time, the output pin shows the busy or ready state. The bus pins form a plain serial port with no valid/ready handshake. The host paces every bit with the serial clock. There is no back-pressure: the only way the block can refuse traffic is by ignoring instructions while it is busy.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A frame starts only when the data input is 1 at a rising serial-clock edge while chip select is high and the block is idle. Zero bits before that edge are ignored.
- R2: After the start bit, the block shifts in a 2-bit opcode and then ADDR_W address bits, MSB first. Opcode 10 is read, 01 is write word and 11 is erase word. Opcode 00 selects by the top two address bits: 11 enable, 10 erase all, 01 write all, 00 disable.
- R3: On a read, the block drives a 0 dummy bit once the last address bit has been taken. On each following rising serial-clock edge it drives the next data bit, MSB first. A read works whether programming is enabled or disabled.
- R4: A write word is followed by DATA_W data bits, MSB first. When programming completes, the addressed word holds exactly that data, whatever its old value was.
- R5: Erase word sets the addressed word to all ones. Erase all sets every word to all ones.
- R6: Write all takes DATA_W data bits and stores them in every word.
- R7: The enable latch is cleared at reset. While it is clear, the four programming commands leave the array unchanged. Enable sets the latch and disable clears it, and the latch keeps its state across frames.
- R8: Programming starts on the falling edge of chip select that ends a complete programming command, and it lasts PROG_CYCLES system clocks.
- R9: When chip select is high and idle after a programming command has started, the data output reads 0 while programming is running and 1 once it has finished.
- R10: An instruction sent while programming is running is ignored and has no effect on the array.
- R11: Chip select low aborts any partial frame without effect, and the output enable is low. The output enable follows chip select after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial bus clock, asynchronous to clk |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data / ready-busy status to host |
| dout_oe_o | output | 1 | High when dout_o is driven |

## Verification
The assertions assume that each serial-clock phase lasts longer than the synchronizer depth plus one system clock, so that every bus edge is seen once and data is stable when it is sampled. They also assume that chip select stays low for at least two system clocks between frames. The stimulus holds each serial-clock phase for four system clocks, changes the data input only while the serial clock is low, and keeps chip select low for four clocks at the end of each frame. The programming time is stretched in the bench so that a whole frame fits inside one busy window.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_READ, ST_DATA, ST_ARMED, ST_DONE
  } mw_state_e;

  typedef enum logic [1:0] {
    PG_WORD_WR, PG_WORD_ER, PG_ALL_WR, PG_ALL_ER
  } pg_op_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_DIS   = 2'b00;
  localparam logic [1:0] EXT_WRALL = 2'b01;
  localparam logic [1:0] EXT_ERALL = 2'b10;
  localparam logic [1:0] EXT_EN    = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[g] <= '0;
      else if (g == 0) chain[g] <= d_i;
      else             chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 40,
  localparam int CYC_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CYC_W-1:0] LOAD = CYC_W'(PROG_CYCLES);
  logic [CYC_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (start_i && cnt == '0)    cnt <= LOAD;
    else if (cnt != '0)               cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CYC_W'(1));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int HDR_W = 2 + ADDR_W,
  localparam int CNT_W = $clog2((HDR_W > DATA_W) ? HDR_W : DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_s,
  input  logic              din_s,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              prog_start_o,
  output pg_op_e            prog_op_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              dout_o
);
  mw_state_e         st;
  logic              sk_q, cs_q, wen, stat_flag, dout_q;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] shreg;
  logic [HDR_W-1:0]  hdr_next;
  logic [1:0]        opc, ext;
  logic              sk_rise, cs_fall;

  assign sk_rise   = sk_s & ~sk_q;
  assign cs_fall   = ~cs_s & cs_q;
  assign hdr_next  = {hdr[HDR_W-2:0], din_s};
  assign opc       = hdr_next[HDR_W-1 -: 2];
  assign ext       = hdr_next[ADDR_W-1 -: 2];
  assign rd_addr_o = hdr_next[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sk_q <= 1'b0; cs_q <= 1'b0; wen <= 1'b0;
      stat_flag <= 1'b0; dout_q <= 1'b0; cnt <= '0; hdr <= '0;
      shreg <= '0; prog_start_o <= 1'b0; prog_op_o <= PG_WORD_WR;
      prog_addr_o <= '0; prog_data_o <= '0;
    end else begin
      sk_q <= sk_s;
      cs_q <= cs_s;
      prog_start_o <= 1'b0;
      if (cs_fall && st == ST_ARMED && wen) begin
        prog_start_o <= 1'b1;
        stat_flag    <= 1'b1;
      end
      if (!cs_s) begin
        st <= ST_IDLE; cnt <= '0; dout_q <= 1'b0;
      end else if (sk_rise) begin
        unique case (st)
          ST_IDLE: if (din_s && !busy_i) begin
            st <= ST_HDR; cnt <= '0; stat_flag <= 1'b0;
          end
          ST_HDR: begin
            hdr <= hdr_next;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_W - 1)) begin
              cnt <= '0;
              prog_addr_o <= rd_addr_o;
              unique case (opc)
                OPC_READ:  begin st <= ST_READ; shreg <= rd_word_i; dout_q <= 1'b0; end
                OPC_WRITE: begin st <= ST_DATA; prog_op_o <= PG_WORD_WR; end
                OPC_ERASE: begin st <= ST_ARMED; prog_op_o <= PG_WORD_ER; end
                default: unique case (ext)
                  EXT_EN:    begin wen <= 1'b1; st <= ST_DONE; end
                  EXT_DIS:   begin wen <= 1'b0; st <= ST_DONE; end
                  EXT_ERALL: begin st <= ST_ARMED; prog_op_o <= PG_ALL_ER; end
                  default:   begin st <= ST_DATA; prog_op_o <= PG_ALL_WR; end
                endcase
              endcase
            end
          end
          ST_READ: begin
            dout_q <= shreg[DATA_W-1];
            shreg  <= {shreg[DATA_W-2:0], 1'b0};
          end
          ST_DATA: begin
            prog_data_o <= {prog_data_o[DATA_W-2:0], din_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) st <= ST_ARMED;
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_o = (st == ST_IDLE && stat_flag) ? ~busy_i : dout_q;

  // R11
  cs_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> st == ST_IDLE);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && st == ST_IDLE) |=> st == ST_IDLE);
  // R3
  read_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && $past(st) == ST_HDR) |-> dout_o == 1'b0);
  // R8
  start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> ($past(cs_q) && !$past(cs_s)));
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 40,
  parameter int SYNC_STAGES = 2,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_oe_o
);
  logic [2:0]        sync_q;
  logic              cs_s, sk_s, din_s;
  logic              busy, done, prog_start;
  pg_op_e            prog_op;
  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [DATA_W-1:0] prog_data, rd_word;
  logic [DATA_W-1:0] mem [WORDS];

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_i, sclk_i, din_i}), .q_o(sync_q));
  assign {cs_s, sk_s, din_s} = sync_q;

  mw_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_s(sk_s), .din_s(din_s),
    .busy_i(busy), .rd_word_i(rd_word), .rd_addr_o(rd_addr),
    .prog_start_o(prog_start), .prog_op_o(prog_op),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .dout_o(dout_o));

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(prog_start),
    .busy_o(busy), .done_o(done));

  assign rd_word   = mem[rd_addr];
  assign dout_oe_o = cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (done) begin
      unique case (prog_op)
        PG_WORD_WR: mem[prog_addr] <= prog_data;
        PG_WORD_ER: mem[prog_addr] <= '1;
        PG_ALL_WR:  for (int i = 0; i < WORDS; i++) mem[i] <= prog_data;
        default:    for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      endcase
    end
  end

  // R5
  erall_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_op == PG_ALL_ER) |=> (mem[0] == '1 && mem[WORDS-1] == '1));
  // R11
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_i) && !cs_s |-> !dout_oe_o);
endmodule

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;
  localparam int PROG = 300;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  int tests = 0, fails = 0;
  logic [15:0] exp_mem [64];
  bit exp_wen = 0;
  logic [1:0] cs_hist = 2'b00;

  always #5 clk = ~clk;

  mw_eeprom_slave #(.PROG_CYCLES(PROG)) u_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sk), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R11: per-clock reference of the output enable (chip select through two stages)
  always @(posedge clk) cs_hist <= rst_n ? {cs_hist[0], cs} : 2'b00;
  always @(negedge clk) if (rst_n) check("R11 oe", {15'd0, dout_oe}, {15'd0, cs_hist[1]});

  task automatic ticks(int n); repeat (n) @(negedge clk); endtask
  task automatic bit_out(logic b); din = b; sk = 1'b0; ticks(4); sk = 1'b1; ticks(4); endtask
  task automatic cs_begin(); sk = 1'b0; din = 1'b0; cs = 1'b1; ticks(4); endtask
  task automatic cs_end(); sk = 1'b0; ticks(2); cs = 1'b0; din = 1'b0; ticks(4); endtask
  task automatic hdr(logic [1:0] op, logic [5:0] a);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 5; i >= 0; i--) bit_out(a[i]);
  endtask
  task automatic word_out(logic [15:0] d);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
  endtask

  task automatic rd(string req, logic [5:0] a, int lead = 0);
    cs_begin();
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    hdr(2'b10, a);
    check({req, " dummy"}, {15'd0, dout}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      sk = 1'b0; ticks(4); sk = 1'b1; ticks(4);
      check(req, {15'd0, dout}, {15'd0, exp_mem[a][i]});
    end
    cs_end();
  endtask

  task automatic wait_ready(string req);
    cs_begin();
    check({req, " busy"}, {15'd0, dout}, 16'd0);
    ticks(PROG + 20);
    check({req, " ready"}, {15'd0, dout}, 16'd1);
    cs_end();
  endtask

  // op: 0 word write, 1 word erase, 2 all write, 3 all erase
  task automatic prog(int op, logic [5:0] a, logic [15:0] d, bit wait_it = 1);
    logic [1:0] opc = (op == 0) ? 2'b01 : (op == 1) ? 2'b11 : 2'b00;
    logic [5:0] ad = (op == 2) ? 6'b010000 : (op == 3) ? 6'b100000 : a;
    cs_begin();
    hdr(opc, ad);
    if (op == 0 || op == 2) word_out(d);
    cs_end();
    if (exp_wen) begin
      for (int i = 0; i < 64; i++) begin
        if (op == 2 || (op == 0 && i == a)) exp_mem[i] = d;
        if (op == 3 || (op == 1 && i == a)) exp_mem[i] = 16'hFFFF;
      end
      if (wait_it) wait_ready("R8 R9");
    end
  endtask

  task automatic ctl(bit en);
    cs_begin(); hdr(2'b00, en ? 6'b110000 : 6'b000000); cs_end();
    exp_wen = en;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'h0000;
    ticks(3);
    check("R11 reset oe", {15'd0, dout_oe}, 16'd0);
    check("R11 reset dout", {15'd0, dout}, 16'd0);
    rst_n = 1'b1;
    ticks(3);
    rd("R3 disabled read", 6'd5);
    prog(0, 6'd5, 16'hAAAA);               // R7 write ignored while disabled
    rd("R7 disabled write", 6'd5);
    ctl(1'b1);                             // R2 enable
    prog(0, 6'd5, 16'hA5C3);
    rd("R4 write", 6'd5);
    prog(0, 6'd63, 16'h1234);
    rd("R4 top word", 6'd63);
    rd("R4 neighbour", 6'd5);
    prog(1, 6'd5, 16'h0);
    rd("R5 erase word", 6'd5);
    // R10: full frame sent while busy
    prog(0, 6'd10, 16'h0F0F, 0);
    cs_begin(); hdr(2'b01, 6'd11); word_out(16'h5555); cs_end();
    wait_ready("R10");
    rd("R10 first", 6'd10);
    rd("R10 ignored", 6'd11);
    // R11: aborted write frame
    cs_begin(); hdr(2'b01, 6'd12); for (int i = 0; i < 8; i++) bit_out(1'b1); cs_end();
    rd("R11 abort", 6'd12);
    rd("R1 leading zeros", 6'd63, 3);
    prog(2, 6'd0, 16'hBEEF);
    rd("R6 wrall lo", 6'd0);
    rd("R6 wrall mid", 6'd33);
    rd("R6 wrall hi", 6'd63);
    prog(3, 6'd0, 16'h0);
    rd("R5 erall", 6'd7);
    rd("R5 erall hi", 6'd62);
    ctl(1'b0);                             // R7 disable
    prog(0, 6'd7, 16'h0000);
    rd("R7 disabled again", 6'd7);
    ctl(1'b1);
    prog(0, 6'd7, 16'h1357);
    rd("R4 no erase needed", 6'd7);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule